// File: doc/BRIEF.md
# NAND Flash Single-Descriptor DMA Engine

This engine moves one buffer of data between system memory and the byte-wide data path of a NAND flash controller. A base register holds the memory address of a four-word buffer descriptor. When the command executor pulses `start` with a direction and a byte length, the engine reads the descriptor over a word-wide memory port, checks it, and then streams the buffer. In the flash-write direction, memory words are fetched and split into bytes for the flash side. In the flash-read direction, bytes received from the flash are packed into memory words and stored.

Each 8-byte memory word carries two 32-bit descriptor words in little-endian lane order. The word at the descriptor base holds the status word in bits 31:0 and the sizes word in bits 63:32. The word at base+8 holds the primary buffer pointer in bits 31:0 and the secondary pointer in bits 63:32. The secondary pointer is never used. When the data has moved, the engine writes the status word back with its ownership bit cleared, then raises a one-cycle completion pulse for the direction it served. A descriptor that fails the checks raises an error pulse instead, and no data moves.

Top module: `ndma_engine`

## Requirements
- R1: On `start`, the engine reads the memory word at the descriptor base, then the word at base+8. The base is the value the base register held before the `start` edge. A `base_we` write in the same cycle as `start` takes effect only for the next transfer.
- R2: A descriptor is accepted only when status bit 31 (owner), bit 3 (first) and bit 2 (last) are all 1. If any of them is 0, `desc_err` pulses for one cycle. In that case no data request is made, no writeback is made, and no flash byte moves.
- R3: The buffer size is sizes bits 11:0 rounded up to a multiple of 8. The transfer length is `len_m1`+1, from 1 to 4096 bytes. A descriptor whose rounded size is smaller than the length is rejected as in R2.
- R4: When `dir`=0, exactly `len_m1`+1 bytes leave on `tx_data`. They are taken in ascending address order from the primary pointer, byte lane 0 of each word first. Padding lanes of the last word are dropped.
- R5: When `dir`=1, exactly `len_m1`+1 bytes taken from `rx_data` are stored at ascending addresses from the primary pointer. Padding lanes in the last word keep their old contents, because their `mem_req_wstrb` bits are 0.
- R6: There is at most one memory request at a time. Addresses are 8-byte aligned, and data addresses step by 8. A request holds its address until accepted. A flash write uses one read per data word, and a flash read uses one write per data word.
- R7: After the data, the engine writes the status word to the descriptor base with bit 31 cleared and the other status bits kept. The strobe is `8'h0F`, so the sizes word is left untouched.
- R8: `tx_done` (for `dir`=0) or `rx_done` (for `dir`=1) pulses for one cycle after the status writeback is accepted. At most one of `tx_done`, `rx_done` and `desc_err` is high in any cycle.
- R9: A `start` received while `busy` is high is ignored.
- R10: While in reset and just after it, `busy`, `mem_req_valid`, `tx_valid`, `rx_ready` and all event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Load the descriptor base register |
| base_wdata | input | ADDR_W | New descriptor base address |
| start | input | 1 | Transfer request from the command executor |
| dir | input | 1 | 0: memory to flash, 1: flash to memory |
| len_m1 | input | LEN_W | Transfer length in bytes minus one |
| busy | output | 1 | A transfer is in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | ADDR_W | Byte address, 8-byte aligned |
| mem_req_wdata | output | 8*BUS_BYTES | Write data |
| mem_req_wstrb | output | BUS_BYTES | Byte-lane write enables |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8*BUS_BYTES | Read data |
| tx_valid | output | 1 | Byte to flash valid |
| tx_data | output | 8 | Byte to flash |
| tx_ready | input | 1 | Flash side takes the byte |
| rx_valid | input | 1 | Byte from flash valid |
| rx_data | input | 8 | Byte from flash |
| rx_ready | output | 1 | Engine takes the byte |
| tx_done | output | 1 | Flash-write transfer complete pulse |
| rx_done | output | 1 | Flash-read transfer complete pulse |
| desc_err | output | 1 | Descriptor rejected pulse |

## Verification
Two events can land in the same cycle:
- A `base_we` write can coincide with the `start` that reads the base. The bench places a valid descriptor at the old base and an unowned one at the new base. It then requires a completion for that transfer and a rejection for the next one.
- A second `start` can arrive while the engine is still busy. The bench holds `start` high with the opposite direction in the middle of a transfer. It requires exactly one completion event, for the original direction, and the memory traffic of exactly one transfer.

Random stalls on the memory, transmit and receive handshakes are switched on and off across the length sweeps. These stalls make the memory, flash and completion boundaries fall on many different cycles.

// File: rtl/ndma_pkg.sv
package ndma_pkg;

  localparam int DESC_W    = 32;
  localparam int OWN_BIT   = 31;
  localparam int FIRST_BIT = 3;
  localparam int LAST_BIT  = 2;
  localparam int SIZE_W    = 12;

  typedef enum logic [3:0] {
    S_IDLE,
    S_F0_REQ,
    S_F0_RSP,
    S_F1_REQ,
    S_F1_RSP,
    S_CHECK,
    S_TX_REQ,
    S_TX_RSP,
    S_TX_DRAIN,
    S_RX_FILL,
    S_RX_WR,
    S_WB
  } ndma_state_e;

endpackage

// File: rtl/ndma_desc_check.sv
module ndma_desc_check
  import ndma_pkg::*;
#(
  parameter int BUS_BYTES = 8,
  parameter int LEN_W     = 12
) (
  input  logic              own_i,
  input  logic              first_i,
  input  logic              last_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [LEN_W-1:0]  len_m1_i,
  output logic              ok_o
);

  localparam int LG = $clog2(BUS_BYTES);

  logic [31:0] padded;
  logic [31:0] need;

  always_comb begin
    padded = ((32'(size_i) + 32'(BUS_BYTES - 1)) >> LG) << LG;
    need   = 32'(len_m1_i) + 32'd1;
    ok_o   = own_i & first_i & last_i & (need <= padded);
  end

endmodule

// File: rtl/ndma_tx_ser.sv
module ndma_tx_ser #(
  parameter int BUS_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load_i,
  input  logic [BUS_BYTES*8-1:0] load_word_i,
  input  logic [$clog2(BUS_BYTES):0] load_cnt_i,
  output logic                   out_valid_o,
  output logic [7:0]             out_data_o,
  input  logic                   out_ready_i,
  output logic                   busy_o
);

  localparam int DW = BUS_BYTES * 8;
  localparam int CW = $clog2(BUS_BYTES) + 1;

  logic [DW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          fire;

  assign out_valid_o = (cnt_q != '0);
  assign out_data_o  = sh_q[7:0];
  assign busy_o      = out_valid_o;
  assign fire        = out_valid_o && out_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (load_i) begin
      cnt_q <= load_cnt_i;
      sh_q  <= load_word_i;
    end else if (fire) begin
      cnt_q <= cnt_q - CW'(1);
      sh_q  <= sh_q >> 8;
    end
  end

  // R4: an offered byte stays put until the flash side takes it
  a_r4_tx_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  // R4: a new word is never loaded over bytes still waiting
  a_r4_no_overload: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !busy_o);

endmodule

// File: rtl/ndma_rx_pack.sv
module ndma_rx_pack #(
  parameter int BUS_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr_i,
  input  logic [$clog2(BUS_BYTES):0] target_i,
  input  logic                   in_valid_i,
  input  logic [7:0]             in_data_i,
  output logic                   in_ready_o,
  output logic                   full_o,
  output logic [BUS_BYTES*8-1:0] word_o,
  output logic [BUS_BYTES-1:0]   strb_o
);

  localparam int DW = BUS_BYTES * 8;
  localparam int CW = $clog2(BUS_BYTES) + 1;

  logic [DW-1:0] word_q;
  logic [CW-1:0] cnt_q;
  logic          fire;

  assign in_ready_o = !clr_i && (cnt_q < target_i);
  assign fire       = in_valid_i && in_ready_o;
  assign full_o     = (target_i != '0) && (cnt_q == target_i);
  assign word_o     = word_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (fire) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (fire) begin
      for (int b = 0; b < BUS_BYTES; b++) begin
        if (cnt_q == CW'(b)) word_q[b*8 +: 8] <= in_data_i;
      end
    end
  end

  for (genvar g = 0; g < BUS_BYTES; g++) begin : g_strb
    assign strb_o[g] = (CW'(g) < cnt_q);
  end

  // R5: the lane counter never runs past one bus word
  a_r5_fill_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(BUS_BYTES));

  // R5: an accepted byte advances the lane count by exactly one
  a_r5_fill_step: assert property (@(posedge clk) disable iff (rst)
    fire |=> cnt_q == $past(cnt_q) + CW'(1));

endmodule

// File: rtl/ndma_engine.sv
module ndma_engine
  import ndma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8,
  parameter int LEN_W     = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   base_we,
  input  logic [ADDR_W-1:0]      base_wdata,
  input  logic                   start,
  input  logic                   dir,
  input  logic [LEN_W-1:0]       len_m1,
  output logic                   busy,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic                   mem_req_we,
  output logic [ADDR_W-1:0]      mem_req_addr,
  output logic [BUS_BYTES*8-1:0] mem_req_wdata,
  output logic [BUS_BYTES-1:0]   mem_req_wstrb,
  input  logic                   mem_rsp_valid,
  input  logic [BUS_BYTES*8-1:0] mem_rsp_data,
  output logic                   tx_valid,
  output logic [7:0]             tx_data,
  input  logic                   tx_ready,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_data,
  output logic                   rx_ready,
  output logic                   tx_done,
  output logic                   rx_done,
  output logic                   desc_err
);

  localparam int DW = BUS_BYTES * 8;
  localparam int LG = $clog2(BUS_BYTES);
  localparam int CW = LG + 1;
  localparam int RW = LEN_W + 1;

  ndma_state_e         state_q;
  logic [ADDR_W-1:0]   base_q;
  logic [ADDR_W-1:0]   cur_base_q;
  logic [ADDR_W-1:0]   ptr_q;
  logic [DESC_W-1:0]   status_q;
  logic [SIZE_W-1:0]   size_q;
  logic [LEN_W-1:0]    len_q;
  logic [RW-1:0]       remain_q;
  logic                dir_q;

  logic [CW-1:0]       chunk;
  logic                last_chunk;
  logic                desc_ok;
  logic                ser_load;
  logic                ser_busy;
  logic [CW-1:0]       pk_target;
  logic                pk_clr;
  logic                pk_full;
  logic [DW-1:0]       pk_word;
  logic [BUS_BYTES-1:0] pk_strb;
  logic                unused_rsp;

  assign unused_rsp = ^mem_rsp_data;

  always_comb begin
    if (remain_q >= RW'(BUS_BYTES)) chunk = CW'(BUS_BYTES);
    else                            chunk = remain_q[CW-1:0];
    last_chunk = (remain_q == RW'(chunk));
  end

  ndma_desc_check #(
    .BUS_BYTES (BUS_BYTES),
    .LEN_W     (LEN_W)
  ) u_check (
    .own_i    (status_q[OWN_BIT]),
    .first_i  (status_q[FIRST_BIT]),
    .last_i   (status_q[LAST_BIT]),
    .size_i   (size_q),
    .len_m1_i (len_q),
    .ok_o     (desc_ok)
  );

  assign ser_load = (state_q == S_TX_RSP) && mem_rsp_valid;

  ndma_tx_ser #(
    .BUS_BYTES (BUS_BYTES)
  ) u_ser (
    .clk         (clk),
    .rst         (rst),
    .load_i      (ser_load),
    .load_word_i (mem_rsp_data),
    .load_cnt_i  (chunk),
    .out_valid_o (tx_valid),
    .out_data_o  (tx_data),
    .out_ready_i (tx_ready),
    .busy_o      (ser_busy)
  );

  assign pk_target = (state_q == S_RX_FILL) ? chunk : '0;
  assign pk_clr    = (state_q == S_RX_WR) && mem_req_ready;

  ndma_rx_pack #(
    .BUS_BYTES (BUS_BYTES)
  ) u_pack (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (pk_clr),
    .target_i   (pk_target),
    .in_valid_i (rx_valid),
    .in_data_i  (rx_data),
    .in_ready_o (rx_ready),
    .full_o     (pk_full),
    .word_o     (pk_word),
    .strb_o     (pk_strb)
  );

  assign busy = (state_q != S_IDLE);

  // memory request decode
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = cur_base_q;
    mem_req_wdata = '0;
    mem_req_wstrb = '0;
    case (state_q)
      S_F0_REQ: mem_req_valid = 1'b1;
      S_F1_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = cur_base_q + ADDR_W'(BUS_BYTES);
      end
      S_TX_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = ptr_q;
      end
      S_RX_WR: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = ptr_q;
        mem_req_wdata = pk_word;
        mem_req_wstrb = pk_strb;
      end
      S_WB: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_wdata = DW'(status_q & ~(DESC_W'(1) << OWN_BIT));
        mem_req_wstrb = BUS_BYTES'((1 << (DESC_W / 8)) - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      base_q     <= '0;
      cur_base_q <= '0;
      ptr_q      <= '0;
      status_q   <= '0;
      size_q     <= '0;
      len_q      <= '0;
      remain_q   <= '0;
      dir_q      <= 1'b0;
      tx_done    <= 1'b0;
      rx_done    <= 1'b0;
      desc_err   <= 1'b0;
    end else begin
      tx_done  <= 1'b0;
      rx_done  <= 1'b0;
      desc_err <= 1'b0;
      if (base_we) base_q <= {base_wdata[ADDR_W-1:LG], LG'(0)};
      case (state_q)
        S_IDLE: begin
          if (start) begin
            cur_base_q <= base_q;
            dir_q      <= dir;
            len_q      <= len_m1;
            remain_q   <= RW'(len_m1) + RW'(1);
            state_q    <= S_F0_REQ;
          end
        end
        S_F0_REQ: if (mem_req_ready) state_q <= S_F0_RSP;
        S_F0_RSP: begin
          if (mem_rsp_valid) begin
            status_q <= mem_rsp_data[DESC_W-1:0];
            size_q   <= mem_rsp_data[DESC_W +: SIZE_W];
            state_q  <= S_F1_REQ;
          end
        end
        S_F1_REQ: if (mem_req_ready) state_q <= S_F1_RSP;
        S_F1_RSP: begin
          if (mem_rsp_valid) begin
            ptr_q   <= {mem_rsp_data[ADDR_W-1:LG], LG'(0)};
            state_q <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (!desc_ok) begin
            desc_err <= 1'b1;
            state_q  <= S_IDLE;
          end else if (dir_q) begin
            state_q  <= S_RX_FILL;
          end else begin
            state_q  <= S_TX_REQ;
          end
        end
        S_TX_REQ: if (mem_req_ready) state_q <= S_TX_RSP;
        S_TX_RSP: if (mem_rsp_valid) state_q <= S_TX_DRAIN;
        S_TX_DRAIN: begin
          if (!ser_busy) begin
            remain_q <= remain_q - RW'(chunk);
            ptr_q    <= ptr_q + ADDR_W'(BUS_BYTES);
            state_q  <= last_chunk ? S_WB : S_TX_REQ;
          end
        end
        S_RX_FILL: if (pk_full) state_q <= S_RX_WR;
        S_RX_WR: begin
          if (mem_req_ready) begin
            remain_q <= remain_q - RW'(chunk);
            ptr_q    <= ptr_q + ADDR_W'(BUS_BYTES);
            state_q  <= last_chunk ? S_WB : S_RX_FILL;
          end
        end
        S_WB: begin
          if (mem_req_ready) begin
            tx_done <= !dir_q;
            rx_done <= dir_q;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R8: the three events are mutually exclusive
  a_r8_one_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_done, rx_done, desc_err}));

  // R8: every event lands with the engine back in idle
  a_r8_event_idle: assert property (@(posedge clk) disable iff (rst)
    (tx_done || rx_done || desc_err) |-> !busy);

  // R6: requests use aligned addresses
  a_r6_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> mem_req_addr[LG-1:0] == '0);

  // R6: a pending request holds until accepted
  a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

  // R2: a rejected descriptor leaves no memory traffic behind
  a_r2_err_quiet: assert property (@(posedge clk) disable iff (rst)
    desc_err |-> !mem_req_valid && !tx_valid);

  // R9: a start while busy does not disturb the latched direction
  a_r9_dir_kept: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(dir_q));

endmodule

// File: tb/ndma_engine_tb.sv
`timescale 1ns/1ps
module ndma_engine_tb;

  localparam int MW = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        start = 1'b0;
  logic        dir = 1'b0;
  logic [11:0] len_m1 = '0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_we;
  logic [31:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic [7:0]  mem_req_wstrb;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data;
  logic        rx_ready;
  logic        tx_done, rx_done, desc_err;

  always #10 clk = ~clk;

  ndma_engine u_dut (
    .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
    .start(start), .dir(dir), .len_m1(len_m1), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_wstrb(mem_req_wstrb),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_done(tx_done), .rx_done(rx_done), .desc_err(desc_err)
  );

  // ---------------- models ----------------
  logic [63:0] mem [MW];
  logic [7:0]  lfsr = 8'h1;
  logic        stall = 1'b0;
  logic        bd_we = 1'b0;
  int          bd_idx = 0;
  logic [63:0] bd_data = '0;
  int          nrd = 0, nwr = 0, ntx = 0, nrx = 0, nerr = 0;
  logic [7:0]  tx_log [8192];
  int          tx_cnt = 0;
  int          rx_idx = 0;

  function automatic logic [7:0] srcb(int a);
    return 8'(a ^ (a >> 5) ^ 'h3C);
  endfunction
  function automatic logic [7:0] rxpat(int i);
    return 8'(i * 5 + 17);
  endfunction

  assign rx_data = rxpat(rx_idx);

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_rsp_valid <= 1'b0;
    if (bd_we) mem[bd_idx] <= bd_data;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        for (int b = 0; b < 8; b++)
          if (mem_req_wstrb[b]) mem[mem_req_addr[12:3]][b*8 +: 8] <= mem_req_wdata[b*8 +: 8];
        nwr <= nwr + 1;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[12:3]];
        nrd <= nrd + 1;
      end
    end
    mem_req_ready <= stall ? lfsr[0] : 1'b1;
    if (tx_valid && tx_ready) begin
      tx_log[tx_cnt % 8192] <= tx_data;
      tx_cnt <= tx_cnt + 1;
    end
    tx_ready <= stall ? lfsr[1] : 1'b1;
    if (rx_valid && rx_ready) begin
      rx_idx   <= rx_idx + 1;
      rx_valid <= stall ? lfsr[2] : 1'b1;
    end else begin
      rx_valid <= rx_valid | (stall ? lfsr[2] : 1'b1);
    end
    if (tx_done)  ntx  <= ntx + 1;
    if (rx_done)  nrx  <= nrx + 1;
    if (desc_err) nerr <= nerr + 1;
  end

  // ---------------- checking ----------------
  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input int addr, input logic [63:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_idx = addr >> 3; bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic put_desc(input int base, input logic [31:0] st, input logic [31:0] sz, input logic [31:0] ptr);
    wr_word(base, {sz, st});
    wr_word(base + 8, {32'h0BAD_0008, ptr});
  endtask

  task automatic fill_src(input int addr, input int nwords);
    for (int w = 0; w < nwords; w++) begin
      logic [63:0] d;
      for (int b = 0; b < 8; b++) d[b*8 +: 8] = srcb(addr + w*8 + b);
      wr_word(addr + w*8, d);
    end
  endtask

  task automatic fill_const(input int addr, input int nwords);
    for (int w = 0; w < nwords; w++) wr_word(addr + w*8, {8{8'hEE}});
  endtask

  task automatic set_base(input int a);
    @(negedge clk); base_we = 1'b1; base_wdata = a;
    @(negedge clk); base_we = 1'b0;
  endtask

  function automatic logic [7:0] mbyte(int a);
    return mem[a >> 3][(a % 8)*8 +: 8];
  endfunction

  int s_rd, s_wr, s_tx, s_rx, s_err, s_txc, s_rxi;
  int g_tx, g_rx, g_err;

  task automatic snap();
    s_rd = nrd; s_wr = nwr; s_tx = ntx; s_rx = nrx; s_err = nerr;
    s_txc = tx_cnt; s_rxi = rx_idx;
  endtask

  task automatic wait_done();
    int n = 0;
    while (((ntx + nrx + nerr) == (s_tx + s_rx + s_err)) && n < 60000) begin
      @(negedge clk); n++;
    end
    chk(n < 60000, "R8 completion timeout", n, 0);
    g_tx = ntx - s_tx; g_rx = nrx - s_rx; g_err = nerr - s_err;
  endtask

  task automatic launch(input logic d, input int len, input bit bw, input int bval);
    snap();
    @(negedge clk);
    start = 1'b1; dir = d; len_m1 = 12'(len - 1);
    base_we = bw; base_wdata = bval;
    @(negedge clk);
    start = 1'b0; base_we = 1'b0;
    wait_done();
  endtask

  task automatic tx_case(input int len, input int size, input int ptr);
    int words = (len + 7) / 8;
    int mism = 0;
    logic [31:0] st = 32'h8000_003C;
    fill_src(ptr, words + 1);
    put_desc(32'h40, st, 32'(size), 32'(ptr));
    launch(1'b0, len, 1'b0, 0);
    chk(g_tx == 1 && g_rx == 0 && g_err == 0, "R8 tx event", {g_tx, g_rx, g_err}, 1);
    chk(tx_cnt - s_txc == len, "R4 tx byte count", tx_cnt - s_txc, len);
    for (int i = 0; i < len; i++)
      if (tx_log[(s_txc + i) % 8192] != srcb(ptr + i)) mism++;
    chk(mism == 0, "R4 tx byte order", mism, 0);
    chk(nrd - s_rd == 2 + words, "R6 tx read count", nrd - s_rd, 2 + words);
    chk(mem[8][31:0] == (st & 32'h7FFF_FFFF), "R7 status writeback", mem[8][31:0], st & 32'h7FFF_FFFF);
    chk(mem[8][63:32] == 32'(size), "R7 sizes untouched", mem[8][63:32], size);
  endtask

  task automatic rx_case(input int len);
    int words = (len + 7) / 8;
    int mism = 0, pad = 0;
    logic [31:0] st = 32'h8000_000C;
    fill_const(32'h100, words + 1);
    put_desc(32'h40, st, 32'(len), 32'h100);
    launch(1'b1, len, 1'b0, 0);
    chk(g_rx == 1 && g_tx == 0 && g_err == 0, "R8 rx event", {g_tx, g_rx, g_err}, 1);
    for (int i = 0; i < len; i++)
      if (mbyte(32'h100 + i) != rxpat(s_rxi + i)) mism++;
    chk(mism == 0, "R5 rx bytes stored", mism, 0);
    for (int i = len; i < (words + 1) * 8; i++)
      if (mbyte(32'h100 + i) != 8'hEE) pad++;
    chk(pad == 0, "R5 padding untouched", pad, 0);
    chk(rx_idx - s_rxi == len, "R5 rx byte count", rx_idx - s_rxi, len);
    chk(nwr - s_wr == words + 1, "R6 rx write count", nwr - s_wr, words + 1);
    chk(mem[8][31:0] == (st & 32'h7FFF_FFFF), "R7 rx status writeback", mem[8][31:0], st & 32'h7FFF_FFFF);
  endtask

  task automatic err_case(input logic [31:0] st, input int size, input int len, input string tag);
    put_desc(32'h40, st, 32'(size), 32'h100);
    launch(1'b0, len, 1'b0, 0);
    chk(g_err == 1 && g_tx == 0 && g_rx == 0, {tag, " error event"}, {g_tx, g_rx, g_err}, 1);
    chk(nrd - s_rd == 2 && nwr == s_wr, {tag, " no data traffic"}, nrd - s_rd, 2);
    chk(tx_cnt == s_txc, {tag, " no flash bytes"}, tx_cnt - s_txc, 0);
    chk(mem[8][31:0] == st, {tag, " status kept"}, mem[8][31:0], st);
  endtask

  initial begin
    #(64'd20 * 64'd190000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: state during reset
    chk(!busy && !mem_req_valid && !tx_valid && !rx_ready && !tx_done && !rx_done && !desc_err,
        "R10 reset outputs", {busy, mem_req_valid, tx_valid, rx_ready}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_req_valid && !tx_done && !rx_done && !desc_err,
        "R10 after reset", {busy, mem_req_valid}, 0);
    set_base(32'h40);

    // R4 R6 R7 R8: memory-to-flash length sweep
    for (int len = 1; len <= 20; len++) begin
      stall = len[0];
      tx_case(len, len, 32'h100);
    end
    // R5 R6 R7 R8: flash-to-memory length sweep
    for (int len = 1; len <= 20; len++) begin
      stall = ~len[0];
      rx_case(len);
    end

    stall = 1'b1;
    // R2: each marker bit missing
    err_case(32'h0000_000C, 16, 16, "R2 owner clear");
    err_case(32'h8000_0008, 16, 16, "R2 last missing");
    err_case(32'h8000_0004, 16, 16, "R2 first missing");
    // R3: size rounding
    err_case(32'h8000_000C, 16, 17, "R3 size too small");
    tx_case(17, 17, 32'h100);   // R3: 17 rounds to 24
    tx_case(16, 9, 32'h100);    // R3: 9 rounds to 16
    tx_case(4096, 12'hFFF, 32'h400); // R3: 4095 rounds to 4096

    // R1: base write in the same cycle as start
    stall = 1'b0;
    put_desc(32'h40, 32'h8000_000C, 4, 32'h100);
    put_desc(32'h80, 32'h0000_000C, 4, 32'h100);
    launch(1'b0, 4, 1'b1, 32'h80);
    chk(g_tx == 1 && g_err == 0, "R1 old base used", {g_tx, g_err}, 1);
    launch(1'b0, 4, 1'b0, 0);
    chk(g_err == 1 && g_tx == 0, "R1 new base next", {g_tx, g_err}, 1);
    chk(mem[16][31:0] == 32'h0000_000C, "R1 unowned status kept", mem[16][31:0], 32'hC);
    set_base(32'h40);

    // R9: start while busy
    stall = 1'b1;
    fill_src(32'h100, 3);
    put_desc(32'h40, 32'h8000_000C, 16, 32'h100);
    snap();
    @(negedge clk); start = 1'b1; dir = 1'b0; len_m1 = 12'd15;
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy, "R9 busy during transfer", busy, 1);
    start = 1'b1; dir = 1'b1; len_m1 = 12'd3;
    repeat (3) @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    chk(ntx - s_tx == 1 && nrx == s_rx && nerr == s_err, "R9 single event",
        {ntx - s_tx, nrx - s_rx}, 1);
    chk(!busy && nrd - s_rd == 4 && nwr - s_wr == 1, "R9 one transfer traffic", nrd - s_rd, 4);
    chk(tx_cnt - s_txc == 16, "R9 tx bytes", tx_cnt - s_txc, 16);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule